// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from board peripherals and turns them into one 4-bit interrupt level for the processor. Each request line has a fixed priority and sets a fixed bit in a 16-bit pending word. A 16-bit enable mask selects which pending bits may compete. The lowest priority number among the enabled, pending sources wins. The winning level is presented inverted (XOR with 15), so the idle state drives 0 and the most urgent source drives 15.

A small register window sits beside the encoder. It holds four registers: the enable mask, a general-purpose 16-bit output latch, a power-off trigger, and a constant version word. The bus is a single-cycle request: the block accepts every request on the clock edge where the valid strobe is high, and it never applies back-pressure. Read data is registered and appears after that edge. A write of 1 to bit 0 of the power-off register produces a one-cycle shutdown pulse.

Top module: `irq_level_agg`

## Requirements
- R1: A synchronous active-high reset clears the enable mask, the pending word, the output latch, the read data register and the shutdown pulse. After reset the level output is 0.
- R2: Source n has priority level n. Its pending/mask bit is fixed: sources 0..12 use bits 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. When only source n is pending and enabled, the level output equals n XOR 15.
- R3: When several sources are both pending and enabled, the one with the smallest level number sets the output. When none qualifies, the resolved level is 15 and the output is 0.
- R4: Request inputs are level-sensitive. The pending word follows the inputs, and the output reflects an input change on the first rising clock edge after it.
- R5: Byte offset 0x00 is the read/write 16-bit enable mask, and all 16 bits read back as written. A mask write changes the output on the same edge that accepts the write, with no input change needed.
- R6: Mask bits 1, 2 and 3 have no source. Setting them never produces a nonzero level.
- R7: Offset 0x36 is a read/write 16-bit latch that drives the general-purpose output pins. Writing it has no effect on the level output or on the shutdown pulse.
- R8: A write to offset 0x30 with write-data bit 0 set raises the shutdown output for exactly one cycle, starting at the edge that accepts the write. A write with bit 0 clear gives no pulse. Reads of 0x30 return 0.
- R9: Offset 0x32 reads as the constant 0x0010. Writes to it are discarded.
- R10: Any other offset, including every odd byte offset, reads as 0 and ignores writes.
- R11: Read data is loaded at the edge that accepts a read. It holds its value through idle cycles and writes until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 13 | Level-sensitive interrupt requests, index = priority level |
| bus_valid_i | input | 1 | Register access strobe, accepted every cycle it is high |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset within the 64-byte window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data, valid the cycle after a read |
| gpo_o | output | 16 | General-purpose output latch |
| shutdown_o | output | 1 | One-cycle power-off request pulse |
| irl_o | output | 4 | Encoded interrupt level (resolved level XOR 15) |

## Verification
The assertions assume three things. First, reset is held from time zero until the first edges have passed. Second, the request lines are already synchronous to the clock. Third, the bus address, write flag and data carry meaning only in cycles where the strobe is high. The bench drives every input on the falling edge, raises the strobe for exactly one cycle per access, and keeps the request lines steady between its sampling points. Each rising edge therefore sees settled, synchronous values, and the properties can relate the previous cycle's inputs to the present outputs without a margin.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  parameter int NUM_SRC = 13;
  parameter int DATA_W  = 16;
  parameter int ADDR_W  = 6;
  parameter int LVL_W   = 4;
  localparam int BIT_W  = $clog2(DATA_W);

  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_VER  = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_GPO  = 6'h36;
  localparam logic [DATA_W-1:0] VERSION_WORD = 16'h0010;

  // pending/mask bit owned by each source (source index = priority level)
  function automatic logic [BIT_W-1:0] src_bit(input int idx);
    case (idx)
      0:  return BIT_W'(11);
      1:  return BIT_W'(9);
      2:  return BIT_W'(8);
      3:  return BIT_W'(12);
      4:  return BIT_W'(10);
      5:  return BIT_W'(6);
      6:  return BIT_W'(5);
      7:  return BIT_W'(4);
      8:  return BIT_W'(7);
      9:  return BIT_W'(14);
      10: return BIT_W'(13);
      11: return BIT_W'(0);
      12: return BIT_W'(15);
      default: return BIT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending
  import irq_level_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [N_SRC-1:0] req_i,
  output logic [W-1:0]     pend_o
);
  logic [W-1:0] pend_d;
  logic [W-1:0] pend_q;

  always_comb begin
    pend_d = '0;
    for (int i = 0; i < N_SRC; i++) begin
      pend_d[src_bit(i)] = req_i[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) pend_q <= '0;
    else       pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_level_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = DATA_W,
  parameter int LW    = LVL_W
) (
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  mask_i,
  output logic [LW-1:0] lvl_o
);
  logic [W-1:0]     qual;
  logic [N_SRC-1:0] hit;
  logic             qual_unused;

  assign qual = pend_i & mask_i;
  assign qual_unused = ^qual;

  for (genvar g = 0; g < N_SRC; g++) begin : g_hit
    assign hit[g] = qual[src_bit(g)];
  end

  // lowest level wins: scan from the top so the last match is the smallest
  always_comb begin
    lvl_o = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hit[i]) lvl_o = LW'(i);
    end
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_level_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  gpo_o,
  output logic          shdn_o
);
  logic [W-1:0] mask_q, gpo_q, rdata_q, rd_val;
  logic         shdn_q;
  logic         wr, rd;

  assign wr = valid_i & write_i;
  assign rd = valid_i & ~write_i;

  // exact match on the full byte offset: odd offsets never hit a register
  always_comb begin
    case (addr_i)
      AW'(OFS_MASK): rd_val = mask_q;
      AW'(OFS_GPO):  rd_val = gpo_q;
      AW'(OFS_VER):  rd_val = W'(VERSION_WORD);
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q  <= '0;
      gpo_q   <= '0;
      rdata_q <= '0;
      shdn_q  <= 1'b0;
    end else begin
      shdn_q <= wr && (addr_i == AW'(OFS_PWR)) && wdata_i[0];
      if (wr && addr_i == AW'(OFS_MASK)) mask_q <= wdata_i;
      if (wr && addr_i == AW'(OFS_GPO))  gpo_q  <= wdata_i;
      if (rd) rdata_q <= rd_val;
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign gpo_o   = gpo_q;
  assign shdn_o  = shdn_q;
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_level_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int LW    = LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [W-1:0]     bus_wdata_i,
  output logic [W-1:0]     bus_rdata_o,
  output logic [W-1:0]     gpo_o,
  output logic             shutdown_o,
  output logic [LW-1:0]    irl_o
);
  logic [W-1:0]  pend_q;
  logic [W-1:0]  mask_q;
  logic [LW-1:0] lvl;

  irq_pending #(.N_SRC(N_SRC), .W(W)) u_pend (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .req_i (req_i),
    .pend_o(pend_q)
  );

  irq_reg_file #(.W(W), .AW(AW)) u_regs (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .valid_i(bus_valid_i),
    .write_i(bus_write_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .mask_o (mask_q),
    .gpo_o  (gpo_o),
    .shdn_o (shutdown_o)
  );

  irq_prio_resolve #(.N_SRC(N_SRC), .W(W), .LW(LW)) u_res (
    .pend_i(pend_q),
    .mask_i(mask_q),
    .lvl_o (lvl)
  );

  // driven only from registered state, so no input-to-output path
  assign irl_o = lvl ^ {LW{1'b1}};
endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk
  import irq_level_pkg::*;
(
  input logic               clk_i,
  input logic               rst_i,
  input logic [NUM_SRC-1:0] req_i,
  input logic               bus_valid_i,
  input logic               bus_write_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic               shutdown_o,
  input logic [LVL_W-1:0]   irl_o,
  input logic [DATA_W-1:0]  mask_q
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(req_i) == '0) |-> irl_o == '0); // R3

  AST_TOP_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(req_i[0]) && mask_q[11]) |-> irl_o == 4'hF); // R2

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(bus_valid_i && bus_write_i && bus_addr_i == OFS_MASK))
      |-> mask_q == $past(bus_wdata_i)); // R5

  AST_SHDN_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    shutdown_o |-> $past(bus_valid_i && bus_write_i && bus_addr_i == OFS_PWR && bus_wdata_i[0])); // R8

  AST_VER_READ: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(bus_valid_i && !bus_write_i && bus_addr_i == OFS_VER))
      |-> bus_rdata_o == VERSION_WORD); // R9

  AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(bus_valid_i && !bus_write_i && bus_addr_i != OFS_MASK
       && bus_addr_i != OFS_GPO && bus_addr_i != OFS_VER)) |-> bus_rdata_o == '0); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(bus_valid_i && !bus_write_i)) |-> $stable(bus_rdata_o)); // R11
endmodule

bind irq_level_agg irq_level_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .req_i      (req_i),
  .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .shutdown_o (shutdown_o),
  .irl_o      (irl_o),
  .mask_q     (mask_q)
);

// File: tb/sim_irq_level_agg.sv
`timescale 1ns/1ps
module sim_irq_level_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] req = '0;
  logic        bv = 1'b0, bw = 1'b0;
  logic [5:0]  ba = '0;
  logic [15:0] bwd = '0;
  logic [15:0] brd, gpo;
  logic        shdn;
  logic [3:0]  irl;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  irq_level_agg u0 (
    .clk_i(clk), .rst_i(rst), .req_i(req), .bus_valid_i(bv), .bus_write_i(bw),
    .bus_addr_i(ba), .bus_wdata_i(bwd), .bus_rdata_o(brd), .gpo_o(gpo),
    .shutdown_o(shdn), .irl_o(irl)
  );

  function automatic int bit_of(input int s);
    int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[s];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bv = 1; bw = 1; ba = a; bwd = d;
    @(negedge clk); bv = 0; bw = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bv = 1; bw = 0; ba = a;
    @(negedge clk); bv = 0; d = brd;
  endtask

  task automatic set_req(input logic [12:0] v);
    @(negedge clk); req = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irl after reset", {12'b0, irl}, 16'h0);
    chk("R1 shutdown after reset", {15'b0, shdn}, 16'h0);
    chk("R1 gpo after reset", gpo, 16'h0);
    chk("R1 rdata after reset", brd, 16'h0);
    rd(6'h00, d);
    chk("R1 mask after reset", d, 16'h0);
  endtask

  task automatic t_sole();
    wr(6'h00, 16'hFFFF);
    for (int s = 0; s < 13; s++) begin
      set_req(13'(1) << s);
      chk($sformatf("R2 sole source %0d", s), {12'b0, irl}, 16'(s ^ 15));
    end
    for (int s = 0; s < 13; s += 4) begin
      wr(6'h00, 16'(1) << bit_of(s));
      set_req(13'(1) << s);
      chk($sformatf("R2 own bit source %0d", s), {12'b0, irl}, 16'(s ^ 15));
      wr(6'h00, ~(16'(1) << bit_of(s)));
      chk($sformatf("R2 other bits source %0d", s), {12'b0, irl}, 16'h0);
    end
  endtask

  task automatic t_prio();
    wr(6'h00, 16'hFFFF);
    set_req(13'h1FFF);
    chk("R3 all pending", {12'b0, irl}, 16'd15);
    set_req(13'h1220);
    chk("R3 sources 5,9,12", {12'b0, irl}, 16'd10);
    set_req(13'h0900);
    chk("R3 sources 8,11", {12'b0, irl}, 16'd7);
    set_req(13'h0);
    chk("R3 none pending", {12'b0, irl}, 16'd0);
  endtask

  task automatic t_level();
    set_req(13'h0080);
    chk("R4 source 7 high", {12'b0, irl}, 16'd8);
    set_req(13'h0);
    chk("R4 source 7 low", {12'b0, irl}, 16'd0);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(6'h00, 16'h0000);
    set_req(13'h1FFF);
    chk("R5 all masked", {12'b0, irl}, 16'd0);
    wr(6'h00, 16'h0400);
    chk("R5 mask write immediate", {12'b0, irl}, 16'd11);
    rd(6'h00, d);
    chk("R5 mask readback", d, 16'h0400);
    wr(6'h00, 16'h000E);
    chk("R6 unsourced bits", {12'b0, irl}, 16'd0);
    rd(6'h00, d);
    chk("R5 unsourced bits readback", d, 16'h000E);
  endtask

  task automatic t_gpo();
    logic [15:0] d;
    wr(6'h00, 16'hFFFF);
    wr(6'h36, 16'hA5C3);
    chk("R7 gpo pins", gpo, 16'hA5C3);
    chk("R7 no shutdown", {15'b0, shdn}, 16'h0);
    chk("R7 level unchanged", {12'b0, irl}, 16'd15);
    rd(6'h36, d);
    chk("R7 gpo readback", d, 16'hA5C3);
  endtask

  task automatic t_pwr();
    logic [15:0] d;
    wr(6'h30, 16'h0001);
    chk("R8 pulse high", {15'b0, shdn}, 16'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {15'b0, shdn}, 16'h0);
    wr(6'h30, 16'hFFFE);
    chk("R8 bit0 clear no pulse", {15'b0, shdn}, 16'h0);
    rd(6'h30, d);
    chk("R8 read zero", d, 16'h0);
  endtask

  task automatic t_ver();
    logic [15:0] d;
    rd(6'h32, d);
    chk("R9 version", d, 16'h0010);
    wr(6'h32, 16'hBEEF);
    rd(6'h32, d);
    chk("R9 write discarded", d, 16'h0010);
  endtask

  task automatic t_unmap();
    logic [15:0] d;
    wr(6'h10, 16'h1234);
    wr(6'h01, 16'h5555);
    wr(6'h37, 16'h5555);
    rd(6'h00, d);
    chk("R10 mask untouched", d, 16'hFFFF);
    chk("R10 gpo untouched", gpo, 16'hA5C3);
    rd(6'h10, d);
    chk("R10 read 0x10", d, 16'h0);
    rd(6'h01, d);
    chk("R10 read odd 0x01", d, 16'h0);
    rd(6'h3E, d);
    chk("R10 read 0x3E", d, 16'h0);
  endtask

  task automatic t_rhold();
    logic [15:0] d;
    rd(6'h32, d);
    repeat (3) @(negedge clk);
    chk("R11 hold idle", brd, 16'h0010);
    wr(6'h36, 16'h0F0F);
    chk("R11 hold over write", brd, 16'h0010);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sole();
    t_prio();
    t_level();
    t_mask();
    t_gpo();
    t_pwr();
    t_ver();
    t_unmap();
    t_rhold();
    summary();
    $finish;
  end
endmodule